// File: doc/BRIEF.md
# Multiplexed-Bus Byte RAM with Gated Hardware Clear

This block is a byte-wide register and RAM peripheral for a multiplexed address/data bus. It has an address latch strobe, active-low read and write strobes, and one eight-bit bus. The bidirectional bus is modelled as an input vector, an output vector and an output enable. A host first places an address on the bus and drops the latch strobe. It then either pulses the write strobe with data on the bus, or pulses the read strobe and samples the data the block drives. All strobes, the bus input and the clear input are brought into the system clock domain through two-flop synchronisers. Edges are detected after synchronisation.

The 128-byte space is split in two. Offsets 0x00 to 0x0D are fourteen control registers that reset to zero. Offsets 0x0E to 0x7F are 114 bytes of user RAM that are not reset. Bit 0 of control register 0x0B enables an active-low hardware clear input. When the clear input falls while the enable bit is set, a sequencer writes zero to the user RAM, one byte per clock. A busy flag is high while this runs, and bus writes are refused until it ends. The control registers are never touched by the clear. The clear acts on its own, whether or not a bus cycle is in progress.

Top module: `mux_bus_ram`

## Requirements
- R1: The address is taken from the bus input on the falling edge of the synchronised latch strobe, and it selects the byte for every later read or write until the next latch.
- R2: On the rising edge of the synchronised write strobe, the bus input value is stored at the latched address, and a later read returns it.
- R3: While the read strobe is low and the write strobe is high, ad_oe_o is 1 and ad_o carries the addressed byte. Within 3 clocks of the read strobe rising, ad_oe_o is 0 and ad_o is 0x00. ad_o is 0x00 whenever ad_oe_o is 0.
- R4: ad_oe_o is 0 whenever the synchronised write strobe is low. If both strobes are low together at any point during a write pulse, that write is dropped.
- R5: Bit 0 of register 0x0B is the clear enable and resets to 0. A falling edge of the synchronised clear input while that bit is 1 zeroes 0x0E..0x7F, one byte per clock in ascending order, with busy_o high for exactly 114 cycles.
- R6: A clear never changes registers 0x00..0x0D. A falling edge of the clear input while the enable bit is 0 changes nothing and leaves busy_o low.
- R7: A bus write whose committing edge falls while busy_o is 1 is ignored, including writes to control registers.
- R8: Addresses 0x80..0xFF read as 0x00, with ad_oe_o still 1 during the read, and writes to them are ignored.
- R9: After reset, ad_oe_o, busy_o and ad_o are 0 and every control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_i | input | 1 | Address latch strobe, address taken on its falling edge |
| rd_n_i | input | 1 | Active-low read strobe |
| wr_n_i | input | 1 | Active-low write strobe, data committed on its rising edge |
| ad_i | input | 8 | Bus value seen by the block (address, then write data) |
| ad_o | output | 8 | Read data driven onto the bus |
| ad_oe_o | output | 1 | Bus output enable |
| clr_n_i | input | 1 | Active-low hardware clear of user RAM |
| busy_o | output | 1 | High while the clear sequence runs |

## Verification
Some rules are checked by the assertions on every cycle: the output enable stays low while the synchronised write strobe is low, the output is zero when not driven, and the bus is released after the read strobe rises. They also check that a clear starts only with the enable bit set, steps its index by one each clock, and never stays busy longer than the user RAM size. Data rules can only be shown by the bench's scenarios, because they need a write followed by a later read. These are: values stored at the latched address, user RAM zeroed while the control registers survive, writes refused while busy, the overlapped read/write that drops its write, and the out-of-range address that reads zero.

// File: rtl/mbr_pkg.sv
`timescale 1ns/1ps
package mbr_pkg;
  // Positions of the strobes inside the synchronised strobe vector
  localparam int STB_ALE = 0;
  localparam int STB_RD  = 1;
  localparam int STB_WR  = 2;
  localparam int STB_CLR = 3;
  localparam int STB_W   = 4;

  // Idle levels: latch strobe low, active-low strobes high
  localparam logic [STB_W-1:0] STB_IDLE = 4'b1110;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_USER = 2'd1,
    SEL_NONE = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/mbr_sync.sv
`timescale 1ns/1ps
module mbr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbr_bus_if.sv
`timescale 1ns/1ps
module mbr_bus_if #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int SPACE  = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_s,
  input  logic              rd_s,
  input  logic              wr_s,
  input  logic [DATA_W-1:0] ad_s,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_o,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o
);
  logic              ale_prev_q, wr_prev_q;
  logic              overlap_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ale_fall, wr_rise;
  logic              in_range;
  logic              drive;

  assign ale_fall = ale_prev_q & ~ale_s;
  assign wr_rise  = ~wr_prev_q & wr_s;
  assign in_range = addr_q < ADDR_W'(SPACE);
  assign drive    = ~rd_s & wr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_prev_q <= 1'b0;
      wr_prev_q  <= 1'b1;
      addr_q     <= '0;
      overlap_q  <= 1'b0;
    end else begin
      ale_prev_q <= ale_s;
      wr_prev_q  <= wr_s;
      if (ale_fall) addr_q <= ad_s;
      if (wr_rise)            overlap_q <= 1'b0;
      else if (~wr_s & ~rd_s) overlap_q <= 1'b1;
    end
  end

  // Commit only a clean write: no read overlap, no clear running, in range
  assign bus_we_o = wr_rise & ~overlap_q & rd_s & ~busy & in_range;
  assign wdata_o  = ad_s;
  assign addr_o   = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ad_oe_o <= 1'b0;
      ad_o    <= '0;
    end else begin
      ad_oe_o <= drive;
      ad_o    <= (drive && in_range) ? rd_data : '0;
    end
  end
endmodule

// File: rtl/mbr_clear.sv
`timescale 1ns/1ps
module mbr_clear #(
  parameter int USER_BYTES = 114,
  localparam int IDX_W = $clog2(USER_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_s,
  input  logic             enable,
  output logic             busy_o,
  output logic             clr_we_o,
  output logic [IDX_W-1:0] clr_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(USER_BYTES - 1);

  logic             clr_prev_q;
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  logic             start;

  assign start = clr_prev_q & ~clr_s & enable & ~busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_prev_q <= 1'b1;
      busy_q     <= 1'b0;
      idx_q      <= '0;
    end else begin
      clr_prev_q <= clr_s;
      if (start) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end else if (busy_q) begin
        if (idx_q == LAST) begin
          busy_q <= 1'b0;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign clr_we_o  = busy_q;
  assign clr_idx_o = idx_q;
endmodule

// File: rtl/mbr_store.sv
`timescale 1ns/1ps
module mbr_store
  import mbr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int SPACE     = 128,
  parameter int CTRL_REGS = 14,
  parameter int EN_REG    = 11,
  parameter int EN_BIT    = 0,
  localparam int USER_BYTES = SPACE - CTRL_REGS,
  localparam int UIDX_W     = $clog2(USER_BYTES),
  localparam int CIDX_W     = $clog2(CTRL_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr_we,
  input  logic [UIDX_W-1:0] clr_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              clr_en_o
);
  logic [DATA_W-1:0] ctrl_q [CTRL_REGS];
  logic [DATA_W-1:0] ram    [USER_BYTES];
  logic [DATA_W-1:0] ram_rd_q, ctrl_rd_q;
  rd_sel_e           sel_q, sel_d;
  logic              is_ctrl, is_user;
  logic [UIDX_W-1:0] uidx;
  logic [CIDX_W-1:0] cidx;
  logic [ADDR_W-1:0] uoff;

  assign is_ctrl = addr < ADDR_W'(CTRL_REGS);
  assign is_user = !is_ctrl && (addr < ADDR_W'(SPACE));
  assign uoff    = addr - ADDR_W'(CTRL_REGS);
  assign uidx    = is_user ? uoff[UIDX_W-1:0] : '0;
  assign cidx    = is_ctrl ? addr[CIDX_W-1:0] : '0;

  always_comb begin
    if (is_ctrl)      sel_d = SEL_CTRL;
    else if (is_user) sel_d = SEL_USER;
    else              sel_d = SEL_NONE;
  end

  // Control registers: flops with reset
  for (genvar r = 0; r < CTRL_REGS; r++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (rst)                                ctrl_q[r] <= '0;
      else if (bus_we && is_ctrl && cidx == CIDX_W'(r)) ctrl_q[r] <= wdata;
    end
  end

  // User RAM: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (clr_we)                ram[clr_idx] <= '0;
    else if (bus_we && is_user) ram[uidx]   <= wdata;
    ram_rd_q <= ram[uidx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_rd_q <= '0;
      sel_q     <= SEL_NONE;
    end else begin
      ctrl_rd_q <= ctrl_q[cidx];
      sel_q     <= sel_d;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_CTRL: rd_data = ctrl_rd_q;
      SEL_USER: rd_data = ram_rd_q;
      default:  rd_data = '0;
    endcase
  end

  assign clr_en_o = ctrl_q[EN_REG][EN_BIT];
endmodule

// File: rtl/mux_bus_ram.sv
`timescale 1ns/1ps
module mux_bus_ram
  import mbr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int SPACE       = 128,
  parameter int CTRL_REGS   = 14,
  parameter int EN_REG      = 11,
  parameter int EN_BIT      = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ale_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic              clr_n_i,
  output logic              busy_o
);
  localparam int USER_BYTES = SPACE - CTRL_REGS;
  localparam int UIDX_W     = $clog2(USER_BYTES);

  logic [STB_W-1:0]  stb_raw, stb_s;
  logic [DATA_W-1:0] ad_s;
  logic              ale_s, rd_s, wr_s, clr_s;
  logic [ADDR_W-1:0] addr;
  logic              bus_we;
  logic [DATA_W-1:0] wdata, rd_data;
  logic              clr_en, clr_we;
  logic [UIDX_W-1:0] clr_idx;

  always_comb begin
    stb_raw          = '0;
    stb_raw[STB_ALE] = ale_i;
    stb_raw[STB_RD]  = rd_n_i;
    stb_raw[STB_WR]  = wr_n_i;
    stb_raw[STB_CLR] = clr_n_i;
  end

  mbr_sync #(.W(STB_W), .STAGES(SYNC_STAGES), .RST_VAL(STB_IDLE)) u_stb_sync (
    .clk(clk), .rst(rst), .d_i(stb_raw), .q_o(stb_s)
  );

  // Bus value delayed by the same depth so it lines up with the strobe edges
  mbr_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_ad_sync (
    .clk(clk), .rst(rst), .d_i(ad_i), .q_o(ad_s)
  );

  assign ale_s = stb_s[STB_ALE];
  assign rd_s  = stb_s[STB_RD];
  assign wr_s  = stb_s[STB_WR];
  assign clr_s = stb_s[STB_CLR];

  mbr_bus_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SPACE(SPACE)) u_bus (
    .clk(clk), .rst(rst),
    .ale_s(ale_s), .rd_s(rd_s), .wr_s(wr_s), .ad_s(ad_s),
    .busy(busy_o), .rd_data(rd_data),
    .addr_o(addr), .bus_we_o(bus_we), .wdata_o(wdata),
    .ad_o(ad_o), .ad_oe_o(ad_oe_o)
  );

  mbr_clear #(.USER_BYTES(USER_BYTES)) u_clear (
    .clk(clk), .rst(rst), .clr_s(clr_s), .enable(clr_en),
    .busy_o(busy_o), .clr_we_o(clr_we), .clr_idx_o(clr_idx)
  );

  mbr_store #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SPACE(SPACE),
    .CTRL_REGS(CTRL_REGS), .EN_REG(EN_REG), .EN_BIT(EN_BIT)
  ) u_store (
    .clk(clk), .rst(rst), .addr(addr), .bus_we(bus_we), .wdata(wdata),
    .clr_we(clr_we), .clr_idx(clr_idx), .rd_data(rd_data), .clr_en_o(clr_en)
  );
endmodule

// File: rtl/mux_bus_ram_chk.sv
`timescale 1ns/1ps
module mux_bus_ram_chk #(
  parameter int DATA_W     = 8,
  parameter int USER_BYTES = 114,
  localparam int IDX_W     = $clog2(USER_BYTES)
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe_o,
  input logic              busy_o,
  input logic              rd_s,
  input logic              wr_s,
  input logic              clr_en,
  input logic [IDX_W-1:0]  clr_idx
);
  logic [IDX_W:0] busy_cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_cnt_q <= '0;
    else                busy_cnt_q <= busy_cnt_q + 1'b1;
  end

  AST_OE_NOT_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_s |=> !ad_oe_o); // R4

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !ad_oe_o |-> ad_o == '0); // R3

  AST_RELEASE_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_s) |=> !ad_oe_o); // R3

  AST_CLEAR_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(clr_en)); // R5

  AST_CLEAR_STEPS_ONE: assert property (@(posedge clk) disable iff (rst)
    busy_o && $past(busy_o) |-> clr_idx == $past(clr_idx) + 1'b1); // R5

  AST_CLEAR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> busy_cnt_q < (IDX_W+1)'(USER_BYTES)); // R5
endmodule

bind mux_bus_ram mux_bus_ram_chk #(.DATA_W(DATA_W), .USER_BYTES(USER_BYTES)) u_chk (
  .clk(clk), .rst(rst), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .busy_o(busy_o),
  .rd_s(rd_s), .wr_s(wr_s), .clr_en(clr_en), .clr_idx(clr_idx)
);

// File: tb/mux_bus_ram_bench.sv
`timescale 1ns/1ps
module mux_bus_ram_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ale = 1'b0, rd_n = 1'b1, wr_n = 1'b1, clr_n = 1'b1;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic       oe, busy;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #5 clk = ~clk;

  mux_bus_ram u_mux_bus_ram (
    .clk(clk), .rst(rst), .ale_i(ale), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(oe), .clr_n_i(clr_n), .busy_o(busy)
  );

  // {address, data} pairs written then read back
  localparam logic [15:0] VEC [8] = '{
    16'h00_3C, 16'h05_A5, 16'h0D_7E, 16'h0E_11,
    16'h2A_C3, 16'h55_0F, 16'h7E_F0, 16'h7F_99
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic latch(input logic [7:0] a);
    ad_in = a; ale = 1'b1; tick(4);
    ale = 1'b0; tick(4);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    latch(a);
    ad_in = d; wr_n = 1'b0; tick(4);
    wr_n = 1'b1; tick(4);
    ad_in = '0; tick(1);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic e);
    latch(a);
    ad_in = '0; rd_n = 1'b0; tick(5);
    @(negedge clk); d = ad_out; e = oe;
    tick(1); rd_n = 1'b1; tick(4);
  endtask

  task automatic pulse_clear;
    clr_n = 1'b0; tick(4);
    clr_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] d;
    logic       e;
    int         cnt;
    tick(3); rst = 1'b0; tick(2);

    // R9 reset state
    @(negedge clk);
    check("R9 oe after reset", oe, 0);
    check("R9 busy after reset", busy, 0);
    check("R9 ad_o after reset", ad_out, 0);
    bus_read(8'h0B, d, e);
    check("R9 reg 0x0B resets to zero", d, 8'h00);

    // R1 R2 vector table
    for (int i = 0; i < 8; i++) bus_write(VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) begin
      bus_read(VEC[i][15:8], d, e);
      check("R2 readback", d, VEC[i][7:0]);
      check("R1 R3 oe during read", e, 1);
    end

    // R3 release within 3 clocks
    latch(8'h05); rd_n = 1'b0; tick(5);
    @(negedge clk);
    check("R3 drive data", ad_out, 8'hA5);
    tick(1); rd_n = 1'b1; tick(3);
    @(negedge clk);
    check("R3 oe released", oe, 0);
    check("R3 ad_o zero when released", ad_out, 0);
    tick(2);

    // R8 out-of-range
    bus_write(8'h90, 8'hAA);
    bus_read(8'h90, d, e);
    check("R8 high address reads zero", d, 8'h00);
    check("R8 oe still asserted", e, 1);

    // R4 overlapped strobes drop the write
    bus_write(8'h20, 8'h11);
    latch(8'h20);
    ad_in = 8'h99; rd_n = 1'b0; wr_n = 1'b0; tick(5);
    @(negedge clk);
    check("R4 oe low while write strobe low", oe, 0);
    tick(1); wr_n = 1'b1; tick(4); rd_n = 1'b1; tick(4); ad_in = '0;
    bus_read(8'h20, d, e);
    check("R4 overlapped write dropped", d, 8'h11);

    // R6 disabled clear does nothing
    pulse_clear(); tick(6);
    check("R6 busy stays low when disabled", busy, 0);
    bus_read(8'h2A, d, e);
    check("R6 RAM intact after disabled clear", d, 8'hC3);

    // R5 enabled clear: busy length and zeroing
    bus_write(8'h0B, 8'h01);
    clr_n = 1'b0;
    cnt = 0;
    for (int k = 0; k < 10 && !busy; k++) @(negedge clk);
    while (busy && cnt < 1000) begin cnt++; @(negedge clk); end
    clr_n = 1'b1; tick(2);
    check("R5 busy cycle count", cnt, 114);
    for (int i = 3; i < 8; i++) begin
      bus_read(VEC[i][15:8], d, e);
      check("R5 user RAM zeroed", d, 8'h00);
    end
    bus_read(8'h20, d, e);
    check("R5 mid RAM zeroed", d, 8'h00);
    for (int i = 0; i < 3; i++) begin
      bus_read(VEC[i][15:8], d, e);
      check("R6 control register kept", d, VEC[i][7:0]);
    end
    bus_read(8'h0B, d, e);
    check("R6 enable bit kept", d, 8'h01);

    // R7 writes ignored while busy
    pulse_clear(); tick(2);
    check("R7 busy before write", busy, 1);
    bus_write(8'h03, 8'h55);
    check("R7 still busy after write", busy, 1);
    tick(120);
    check("R7 clear finished", busy, 0);
    bus_read(8'h03, d, e);
    check("R7 write during busy ignored", d, 8'h00);
    bus_write(8'h03, 8'h66);
    bus_read(8'h03, d, e);
    check("R7 write accepted after busy", d, 8'h66);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule